// File: doc/BRIEF.md
# Byte-Wide Write-Once Memory Target Model

This block is a synthesizable stand-in for a byte-wide, ultraviolet-erasable, one-time-writable memory device, used as the target when exercising a device programmer in simulation or on an FPGA. It takes a 17-bit address, an 8-bit write bus, and active-low chip-select, output-gate and program-strobe inputs. Three level flags replace the analog conditions: programming supply raised, supply voltage elevated, and high voltage present on address line 9. It returns an 8-bit read bus and an enable for an external tri-state driver.

The operating mode is decoded from the strobes and the flags: standby, output-off, read, identification, program, program-verify and program-inhibit. A write can only clear bits. The stored byte becomes the old byte ANDed with the presented byte. A write is committed on the rising edge of the program strobe, and only when that strobe was low for no more than a set number of clock cycles. A bulk-erase input returns every location to all ones. The array depth is a parameter. Address bits above the depth alias onto the same cells.

Top module: `otp_store`

## Requirements
- R1: After reset, and at every clock edge after an edge at which `erase` was high, every location reads 0xFF.
- R2: A committed write stores the old byte ANDed with `din`. A 1 in `din` leaves that bit unchanged, so a second write to a location can only clear further bits.
- R3: `dout_en` is combinational and is high exactly when `ce_n` and `oe_n` are both low.
- R4: While `ce_n` is high, `dout_en` is low whatever the level of `oe_n`.
- R5: Reads are registered. `dout` after a clock edge is the content of the location chosen by the `DEPTH_W` low address bits at that edge, so the upper bits alias. `dout` is 0x00 after reset.
- R6: With `vpp_hi` low, program strobes never write, whatever the other inputs are.
- R7: A write commits at the first clock edge that samples `pgm_n` high after it was sampled low, only if at that edge `ce_n`=0, `oe_n`=1, `vpp_hi`=1 and `vcc_hi`=1. `addr` and `din` are taken at that edge.
- R8: With `ce_n` high, a program strobe under raised supplies writes nothing (inhibit).
- R9: With `vpp_hi` high and both `ce_n` and `oe_n` low, the read returns stored contents (verify).
- R10: With `vpp_hi` low, `ce_n`=`oe_n`=0 and `a9_hv` high, the read returns 0x8F when addr bit 0 is 0 and 0x86 when it is 1, provided every address bit other than bits 0 and 9 is 0. Otherwise it returns 0xFF.
- R11: The strobe width is the number of clock edges that sampled `pgm_n` low. A width up to `PULSE_MAX` (default 16) commits. A larger width is discarded. `dc_fault` is high while the current low count exceeds `PULSE_MAX`, and it is low after any edge that samples `pgm_n` high.
- R12: If a commit and `erase` fall on the same edge, erase wins and the location reads 0xFF. A later write starts from 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset; leaves the array erased |
| addr | input | 17 | Byte address |
| din | input | 8 | Byte presented for programming |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply raised |
| vcc_hi | input | 1 | Supply voltage elevated for programming |
| a9_hv | input | 1 | High voltage on address line 9 (identification) |
| erase | input | 1 | Bulk erase to all ones |
| dout | output | 8 | Registered read data |
| dout_en | output | 1 | Tri-state driver enable |
| dc_fault | output | 1 | Program strobe held low too long |

## Verification
A program commit and a bulk erase can land on the same clock edge. Both act on the per-location written flags and on the array. The bench provokes this by raising the program strobe and `erase` in the same half-cycle. The outcome is judged by reading that location as 0xFF, then by checking that a fresh write merges with 0xFF rather than with stale array contents.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_DARK,
    MD_READ,
    MD_IDCODE,
    MD_PROGRAM,
    MD_VERIFY
  } otp_mode_e;

  // Mode priority: select first, then programming supply, then output gate.
  function automatic otp_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                            input logic vpp_hi, input logic a9_hv);
    if (ce_n)   return vpp_hi ? MD_INHIBIT : MD_STANDBY;
    if (vpp_hi) return oe_n ? MD_PROGRAM : MD_VERIFY;
    if (oe_n)   return MD_DARK;
    return a9_hv ? MD_IDCODE : MD_READ;
  endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic ce_n,
  input  logic oe_n,
  input  logic vpp_hi,
  input  logic vcc_hi,
  input  logic a9_hv,
  output logic drive_en,
  output logic rd_id,
  output logic prog_window
);

  otp_mode_e mode;

  always_comb begin
    mode        = decode_mode(ce_n, oe_n, vpp_hi, a9_hv);
    drive_en    = (mode == MD_READ) || (mode == MD_IDCODE) || (mode == MD_VERIFY);
    rd_id       = (mode == MD_IDCODE);
    prog_window = (mode == MD_PROGRAM) && vcc_hi;
  end

endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int unsigned PULSE_MAX = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  input  logic window,
  output logic commit,
  output logic dc_fault
);

  localparam int unsigned CAP = PULSE_MAX + 1;
  localparam int unsigned CW  = $clog2(CAP + 1);

  logic [CW-1:0] low_cnt;
  logic          pgm_q;
  logic          rise;
  logic          width_ok;

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c);
    return (c >= CW'(CAP)) ? c : c + CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      pgm_q   <= 1'b1;
    end else begin
      pgm_q   <= pgm_n;
      low_cnt <= pgm_n ? '0 : bump(low_cnt);
    end
  end

  assign rise     = pgm_n & ~pgm_q;
  assign width_ok = (low_cnt <= CW'(PULSE_MAX));
  assign commit   = rise & window & width_ok;
  assign dc_fault = (low_cnt > CW'(PULSE_MAX));

  // R11: a sampled-high strobe always clears the fault on the next cycle
  assert_fault_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_n |=> !dc_fault);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               erase,
  input  logic               we,
  input  logic [DEPTH_W-1:0] idx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rd_id,
  input  logic [DATA_W-1:0]  id_byte,
  output logic [DATA_W-1:0]  rd_data
);

  localparam int unsigned        DEPTH = 1 << DEPTH_W;
  localparam logic [DATA_W-1:0]  BLANK = '1;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  burned;
  logic [DATA_W-1:0] cell_now;
  logic [DATA_W-1:0] merged;

  function automatic logic [DATA_W-1:0] peek(input logic [DEPTH_W-1:0] i);
    return burned[i] ? store[i] : BLANK;
  endfunction

  function automatic logic [DATA_W-1:0] clear_only(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v);
    return old_v & new_v;
  endfunction

  assign cell_now = burned[idx] ? store[idx] : BLANK;
  assign merged   = clear_only(cell_now, wdata);

  always_ff @(posedge clk) begin
    if (we) store[idx] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       burned <= '0;
    else if (erase)   burned <= '0;
    else if (we)      burned[idx] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_id ? id_byte : cell_now;
  end

  // R1 / R12: erase leaves no location marked written, even with a write on the same edge
  assert_erase_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (burned == '0));

  // R2: a write never turns a 0 bit into a 1
  assert_no_bit_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !erase) |=> ((peek($past(idx)) & ~$past(cell_now)) == '0));

endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int unsigned     ADDR_W    = 17,
  parameter int unsigned     DATA_W    = 8,
  parameter int unsigned     DEPTH_W   = 8,
  parameter int unsigned     PULSE_MAX = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h8F,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              vcc_hi,
  input  logic              a9_hv,
  input  logic              erase,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              dc_fault
);

  localparam logic [ADDR_W-1:0] ID_SKIP = ADDR_W'(1) | (ADDR_W'(1) << 9);

  logic              rd_id;
  logic              prog_window;
  logic              commit;
  logic [DATA_W-1:0] id_byte;
  logic              armed;

  function automatic logic [DATA_W-1:0] id_pick(input logic [ADDR_W-1:0] a);
    if ((a & ~ID_SKIP) != '0) return '1;
    return a[0] ? DEV_CODE : MFR_CODE;
  endfunction

  assign id_byte = id_pick(addr);

  otp_mode_decode u_decode (
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .vpp_hi      (vpp_hi),
    .vcc_hi      (vcc_hi),
    .a9_hv       (a9_hv),
    .drive_en    (dout_en),
    .rd_id       (rd_id),
    .prog_window (prog_window)
  );

  otp_pulse_timer #(.PULSE_MAX(PULSE_MAX)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .pgm_n    (pgm_n),
    .window   (prog_window),
    .commit   (commit),
    .dc_fault (dc_fault)
  );

  otp_cell_array #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase   (erase),
    .we      (commit),
    .idx     (addr[DEPTH_W-1:0]),
    .wdata   (din),
    .rd_id   (rd_id),
    .id_byte (id_byte),
    .rd_data (dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R4: deselected device never drives
  assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  // R3: output gate high keeps the driver off
  assert_gate_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en);
  // R8: inhibit blocks writes
  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !commit);
  // R6: normal read mode never writes
  assert_read_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_hi |-> !commit);
  // R11: an over-long strobe never commits on its release
  assert_overlong_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_fault && pgm_n) |-> !commit);
  // R10: identification at address zero yields the maker code
  assert_idcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(rd_id && (addr == '0))) |-> (dout == MFR_CODE));

endmodule

// File: tb/otp_store_bench.sv
module otp_store_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PMAX       = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] addr;
  logic [7:0]  din;
  logic        ce_n, oe_n, pgm_n, vpp_hi, vcc_hi, a9_hv, erase;
  logic [7:0]  dout;
  logic        dout_en, dc_fault;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  otp_store #(.PULSE_MAX(PMAX)) u_otp_store (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_hi(vpp_hi), .vcc_hi(vcc_hi), .a9_hv(a9_hv), .erase(erase),
    .dout(dout), .dout_en(dout_en), .dc_fault(dc_fault)
  );

  // {address, first byte, second byte}; expected = first AND second
  localparam logic [32:0] VEC [8] = '{
    {17'h00010, 8'hF0, 8'h3C},
    {17'h00011, 8'hFF, 8'h00},
    {17'h00020, 8'hA5, 8'h5A},
    {17'h00021, 8'hFE, 8'hFF},
    {17'h1FF22, 8'h7F, 8'hF7},
    {17'h000FF, 8'h81, 8'hC3},
    {17'h00130, 8'hEE, 8'hDD},
    {17'h00000, 8'h0F, 8'h0F}
  };

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1;
    vpp_hi = 1'b0; vcc_hi = 1'b0; a9_hv = 1'b0; erase = 1'b0;
  endtask

  task automatic prog(input logic [16:0] a, input logic [7:0] d, input int width,
                      input logic ce_v, input logic vpp_v, input logic vcc_v,
                      output logic flt);
    @(negedge clk);
    addr = a; din = d; ce_n = ce_v; oe_n = 1'b1; a9_hv = 1'b0;
    vpp_hi = vpp_v; vcc_hi = vcc_v; pgm_n = 1'b0;
    repeat (width) @(negedge clk);
    flt = dc_fault;
    pgm_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [16:0] a, input logic vpp_v, input logic a9_v,
                    output logic [7:0] q);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; pgm_n = 1'b1;
    vpp_hi = vpp_v; vcc_hi = vpp_v; a9_hv = a9_v;
    @(negedge clk);
    q = dout;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1..: got hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic       f;
    idle();
    addr = '0; din = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk8("R5 reset dout", dout, 8'h00);
    chk1("R4 reset dout_en", dout_en, 1'b0);
    rst_n = 1'b1;

    rd(17'h00003, 1'b0, 1'b0, q);
    chk8("R1 erased after reset", q, 8'hFF);

    // Vector walk: two writes each, then read back the merged byte
    for (int i = 0; i < 8; i++) begin
      prog(VEC[i][32:16], VEC[i][15:8], 1 + (i % 3), 1'b0, 1'b1, 1'b1, f);
      prog(VEC[i][32:16], VEC[i][7:0], 2, 1'b0, 1'b1, 1'b1, f);
      rd(VEC[i][32:16], 1'b0, 1'b0, q);
      chk8($sformatf("R2 R7 vector %0d", i), q, VEC[i][15:8] & VEC[i][7:0]);
    end

    rd(17'h10030, 1'b0, 1'b0, q);
    chk8("R5 upper address bits alias", q, 8'hEE & 8'hDD);

    // Tri-state enable combinations, checked combinationally
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b0; #1;
    chk1("R4 ce high oe low", dout_en, 1'b0);
    ce_n = 1'b0; oe_n = 1'b1; #1;
    chk1("R3 ce low oe high", dout_en, 1'b0);
    ce_n = 1'b0; oe_n = 1'b0; #1;
    chk1("R3 ce low oe low", dout_en, 1'b1);
    ce_n = 1'b1; oe_n = 1'b1; #1;
    chk1("R4 both high", dout_en, 1'b0);

    prog(17'h00040, 8'h00, 2, 1'b0, 1'b0, 1'b1, f);
    rd(17'h00040, 1'b0, 1'b0, q);
    chk8("R6 strobe without programming supply", q, 8'hFF);

    prog(17'h00041, 8'h00, 2, 1'b0, 1'b1, 1'b0, f);
    rd(17'h00041, 1'b0, 1'b0, q);
    chk8("R7 strobe without elevated supply", q, 8'hFF);

    prog(17'h00042, 8'h00, 2, 1'b1, 1'b1, 1'b1, f);
    rd(17'h00042, 1'b0, 1'b0, q);
    chk8("R8 inhibited device", q, 8'hFF);

    rd(17'h00010, 1'b1, 1'b0, q);
    chk8("R9 verify read", q, 8'h30);

    rd(17'h00000, 1'b0, 1'b1, q);
    chk8("R10 maker code", q, 8'h8F);
    rd(17'h00001, 1'b0, 1'b1, q);
    chk8("R10 device code", q, 8'h86);
    rd(17'h00201, 1'b0, 1'b1, q);
    chk8("R10 bit 9 ignored", q, 8'h86);
    rd(17'h00003, 1'b0, 1'b1, q);
    chk8("R10 other bit set", q, 8'hFF);

    prog(17'h00050, 8'h0F, PMAX, 1'b0, 1'b1, 1'b1, f);
    chk1("R11 fault at limit width", f, 1'b0);
    rd(17'h00050, 1'b0, 1'b0, q);
    chk8("R11 limit width commits", q, 8'h0F);

    prog(17'h00051, 8'h00, PMAX + 1, 1'b0, 1'b1, 1'b1, f);
    chk1("R11 fault beyond limit", f, 1'b1);
    chk1("R11 fault cleared after release", dc_fault, 1'b0);
    rd(17'h00051, 1'b0, 1'b0, q);
    chk8("R11 over-long strobe discarded", q, 8'hFF);

    @(negedge clk); idle(); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    rd(17'h00010, 1'b0, 1'b0, q);
    chk8("R1 bulk erase location 0x10", q, 8'hFF);
    rd(17'h00050, 1'b0, 1'b0, q);
    chk8("R1 bulk erase location 0x50", q, 8'hFF);

    // R12: commit and erase on the same edge
    @(negedge clk);
    addr = 17'h00060; din = 8'h00; ce_n = 1'b0; oe_n = 1'b1;
    vpp_hi = 1'b1; vcc_hi = 1'b1; a9_hv = 1'b0; pgm_n = 1'b0;
    repeat (2) @(negedge clk);
    pgm_n = 1'b1; erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    rd(17'h00060, 1'b0, 1'b0, q);
    chk8("R12 erase wins over commit", q, 8'hFF);
    prog(17'h00060, 8'hB6, 1, 1'b0, 1'b1, 1'b1, f);
    rd(17'h00060, 1'b0, 1'b0, q);
    chk8("R12 later write starts blank", q, 8'hB6);

    done = 1'b1;
    report();
    $finish;
  end

endmodule